// File: doc/BRIEF.md
# Run-time Accuracy-Tunable Unsigned Multiplier

This block multiplies two unsigned 8-bit operands and returns a 16-bit product one clock after the operands are presented. A 2-bit accuracy level chooses how the partial-product bits in the low-order columns are reduced. Level 0 is exact. Levels 1, 2 and 3 replace the exact reduction of the lowest 4, 6 or 8 columns with cheap 4-input approximate compressors. A second control vector can cut carry propagation at chosen bit positions of the final two-row adder. Cutting carries shortens the carry chain and makes the result less accurate.

The partial products are grouped four rows at a time. Rows come from operand-B bits 0-3 and bits 4-7. In every approximated column, each group's four bits collapse to an OR bit in that column and an AND-of-all-four bit one column higher. All higher columns go through an exact carry-save tree. The last two rows are summed by an adder in which any bit position can be switched to OR mode. An OR-mode position produces the OR of its two inputs, generates no carry and ignores the carry arriving from below. Every approximation can only lower the sum, so the error is one-sided, and its size is limited by the selected span.

Top module: `acc_mult`

## Requirements
- R1: While `rst` is high on a rising edge, `product` becomes 0 on that edge.
- R2: `product` changes only on a rising edge. It reflects the operands and controls sampled on that edge, one cycle of latency.
- R3: At accuracy level 0, `product` equals op_a*op_b for every operand pair, whatever the value of `carry_cut`.
- R4: At levels 1, 2 and 3 the approximated span is columns 0-3, 0-5 and 0-7 respectively. For any operands and any `carry_cut`, the product never exceeds op_a*op_b.
- R5: With `carry_cut` zero, the shortfall op_a*op_b - product is at most the sum of (c+1)*2^c over the approximated columns c. This gives 49, 321 and 1793 for levels 1, 2 and 3. Some operand pair gives a nonzero shortfall at every nonzero level.
- R6: With `carry_cut` zero, if either operand has its lowest K bits all zero (K being the span of the level), the product is exact.
- R7: In an approximated column, a group's four bits produce their OR in that column and their four-way AND one column up. For example, 3*3 yields 7 at every nonzero level.
- R8: At a nonzero level, setting any `carry_cut` bits never raises the product above the result with `carry_cut` zero for the same operands and level.
- R9: At a nonzero level with every `carry_cut` bit set, twice the product is at least the result obtained with `carry_cut` zero.
- R10: If either operand has at most one bit set, the product is exact at every level and for every `carry_cut`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the product register |
| op_a | input | 8 | Unsigned multiplicand |
| op_b | input | 8 | Unsigned multiplier; its bits select partial-product rows |
| acc_lvl | input | 2 | Accuracy level: 0 exact, 1/2/3 approximate low 4/6/8 columns |
| carry_cut | input | 16 | Bit i set puts final-adder position i in OR mode (ignored at level 0) |
| product | output | 16 | Registered product |

## Verification
The carry-cut positions act on two internal rows whose values cannot be set directly from the ports, so their effect cannot be predicted exactly from outside. The stimulus therefore sends each random operand pair three times at the same level: first with no cuts, then with a random cut vector, then with every position cut. It then checks the ordering and halving relations between these three results. The worst-case shortfall at each level is found by a dense sweep of operand pairs and compared with the analytic bound. Operands chosen to be exact (powers of two, zero low bits) must produce exact products under every cut vector.

// File: rtl/acc_mult_pkg.sv
package acc_mult_pkg;

  typedef enum logic [1:0] {
    ACC_EXACT = 2'd0,
    ACC_LOW_S = 2'd1,
    ACC_LOW_M = 2'd2,
    ACC_LOW_L = 2'd3
  } acc_level_e;

  // rows remaining after lvl layers of 3:2 compression
  function automatic int csa_rows_after(input int n, input int lvl);
    int r;
    r = n;
    for (int i = 0; i < lvl; i++) r = (r / 3) * 2 + (r % 3);
    return r;
  endfunction

  // layers needed to bring n rows down to two
  function automatic int csa_depth(input int n);
    int r;
    int d;
    r = n;
    d = 0;
    while (r > 2) begin
      r = (r / 3) * 2 + (r % 3);
      d++;
    end
    return d;
  endfunction

endpackage

// File: rtl/acc_mult_ppgen.sv
module acc_mult_ppgen #(
  parameter int W    = 8,
  parameter int NROW = 8
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-1:0] rows [NROW]
);
  localparam int PW = 2 * W;

  for (genvar j = 0; j < NROW; j++) begin : g_row
    if (j < W) begin : g_live
      assign rows[j] = PW'(a & {W{b[j]}}) << j;
    end else begin : g_pad
      assign rows[j] = '0;
    end
  end
endmodule

// File: rtl/acc_mult_approx.sv
// Four-row groups; in enabled columns each group collapses to OR (same
// column) and four-way AND (next column). Other columns pass unchanged.
module acc_mult_approx #(
  parameter int PW   = 16,
  parameter int NGRP = 2
) (
  input  logic [PW-1:0] rows_in  [4*NGRP],
  input  logic [PW-1:0] col_en,
  output logic [PW-1:0] rows_out [5*NGRP]
);
  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    logic [PW-1:0] or_v;
    logic [PW-1:0] and_v;
    assign or_v  = rows_in[4*g] | rows_in[4*g+1] | rows_in[4*g+2] | rows_in[4*g+3];
    assign and_v = rows_in[4*g] & rows_in[4*g+1] & rows_in[4*g+2] & rows_in[4*g+3];

    assign rows_out[5*g] = (rows_in[4*g] & ~col_en) | (or_v & col_en);
    for (genvar k = 1; k < 4; k++) begin : g_keep
      assign rows_out[5*g+k] = rows_in[4*g+k] & ~col_en;
    end
    assign rows_out[5*g+4] = (and_v & col_en) << 1;
  end
endmodule

// File: rtl/acc_mult_csa3.sv
module acc_mult_csa3 #(
  parameter int PW = 16
) (
  input  logic [PW-1:0] x,
  input  logic [PW-1:0] y,
  input  logic [PW-1:0] z,
  output logic [PW-1:0] s,
  output logic [PW-1:0] c
);
  assign s = x ^ y ^ z;
  assign c = ((x & y) | (x & z) | (y & z)) << 1;
endmodule

// File: rtl/acc_mult_csa_tree.sv
module acc_mult_csa_tree
  import acc_mult_pkg::*;
#(
  parameter int PW  = 16,
  parameter int NIN = 10
) (
  input  logic [PW-1:0] rows_in [NIN],
  output logic [PW-1:0] sum_a,
  output logic [PW-1:0] sum_b
);
  localparam int DEPTH = csa_depth(NIN);

  logic [PW-1:0] lvl [DEPTH+1][NIN];

  for (genvar r = 0; r < NIN; r++) begin : g_in
    assign lvl[0][r] = rows_in[r];
  end

  for (genvar l = 0; l < DEPTH; l++) begin : g_lvl
    localparam int N_IN  = csa_rows_after(NIN, l);
    localparam int N_FA  = N_IN / 3;
    localparam int N_OUT = csa_rows_after(NIN, l + 1);
    for (genvar t = 0; t < N_FA; t++) begin : g_csa
      acc_mult_csa3 #(.PW(PW)) u_csa (
        .x(lvl[l][3*t]),
        .y(lvl[l][3*t+1]),
        .z(lvl[l][3*t+2]),
        .s(lvl[l+1][2*t]),
        .c(lvl[l+1][2*t+1])
      );
    end
    for (genvar r = 0; r < N_IN - 3*N_FA; r++) begin : g_pass
      assign lvl[l+1][2*N_FA+r] = lvl[l][3*N_FA+r];
    end
    for (genvar r = N_OUT; r < NIN; r++) begin : g_zero
      assign lvl[l+1][r] = '0;
    end
  end

  assign sum_a = lvl[DEPTH][0];
  assign sum_b = lvl[DEPTH][1];
endmodule

// File: rtl/acc_mult_cma.sv
// Ripple adder whose positions can each be cut to OR mode.
module acc_mult_cma #(
  parameter int PW = 16
) (
  input  logic [PW-1:0] x,
  input  logic [PW-1:0] y,
  input  logic [PW-1:0] cut,
  output logic [PW-1:0] sum
);
  logic [PW-1:0] cy;
  assign cy[0] = 1'b0;

  for (genvar i = 0; i < PW; i++) begin : g_bit
    assign sum[i] = cut[i] ? (x[i] | y[i]) : (x[i] ^ y[i] ^ cy[i]);
    if (i < PW - 1) begin : g_cy
      assign cy[i+1] = cut[i] ? 1'b0 : ((x[i] & y[i]) | (cy[i] & (x[i] ^ y[i])));
    end
  end
endmodule

// File: rtl/acc_mult.sv
module acc_mult
  import acc_mult_pkg::*;
#(
  parameter int W         = 8,
  parameter int SPAN_BASE = 4,
  parameter int SPAN_STEP = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [W-1:0]   op_a,
  input  logic [W-1:0]   op_b,
  input  logic [1:0]     acc_lvl,
  input  logic [2*W-1:0] carry_cut,
  output logic [2*W-1:0] product
);
  localparam int PW   = 2 * W;
  localparam int NGRP = (W + 3) / 4;
  localparam int NROW = 4 * NGRP;
  localparam int NRED = 5 * NGRP;
  localparam int SW   = $clog2(PW + 1);

  logic [PW-1:0] pp_rows  [NROW];
  logic [PW-1:0] red_rows [NRED];
  logic [PW-1:0] col_en;
  logic [PW-1:0] cut_eff;
  logic [PW-1:0] fin_a;
  logic [PW-1:0] fin_b;
  logic [PW-1:0] sum_w;
  logic [SW-1:0] span;

  always_comb begin
    if (acc_lvl == ACC_EXACT) begin
      span = '0;
    end else begin
      span = SW'(SPAN_BASE + SPAN_STEP * (int'(acc_lvl) - 1));
    end
    col_en  = (PW'(1) << span) - PW'(1);
    cut_eff = (acc_lvl == ACC_EXACT) ? '0 : carry_cut;
  end

  acc_mult_ppgen #(.W(W), .NROW(NROW)) u_ppgen (
    .a   (op_a),
    .b   (op_b),
    .rows(pp_rows)
  );

  acc_mult_approx #(.PW(PW), .NGRP(NGRP)) u_approx (
    .rows_in (pp_rows),
    .col_en  (col_en),
    .rows_out(red_rows)
  );

  acc_mult_csa_tree #(.PW(PW), .NIN(NRED)) u_tree (
    .rows_in(red_rows),
    .sum_a  (fin_a),
    .sum_b  (fin_b)
  );

  acc_mult_cma #(.PW(PW)) u_cma (
    .x  (fin_a),
    .y  (fin_b),
    .cut(cut_eff),
    .sum(sum_w)
  );

  always_ff @(posedge clk) begin
    if (rst) product <= '0;
    else     product <= sum_w;
  end
endmodule

// File: rtl/acc_mult_chk.sv
module acc_mult_chk #(
  parameter int W = 8
) (
  input logic           clk,
  input logic           rst,
  input logic [W-1:0]   op_a,
  input logic [W-1:0]   op_b,
  input logic [1:0]     acc_lvl,
  input logic [2*W-1:0] product
);
  localparam int PW = 2 * W;

  // R1
  reset_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> product == '0);

  // R3
  exact_level_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(acc_lvl) == 2'd0)
      |-> product == PW'($past(op_a)) * PW'($past(op_b)));

  // R4
  no_excess_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> product <= PW'($past(op_a)) * PW'($past(op_b)));

  // R10
  sparse_exact_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($countones($past(op_a)) <= 1 || $countones($past(op_b)) <= 1))
      |-> product == PW'($past(op_a)) * PW'($past(op_b)));
endmodule

bind acc_mult acc_mult_chk #(.W(W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .op_a   (op_a),
  .op_b   (op_b),
  .acc_lvl(acc_lvl),
  .product(product)
);

// File: tb/acc_mult_test.sv
`timescale 1ns/1ps
module acc_mult_test;
  localparam int W  = 8;
  localparam int PW = 16;
  localparam int WD_CYCLES = 190000;

  localparam int K_EXACT = 0;
  localparam int K_APPX  = 1;
  localparam int K_BASE  = 2;
  localparam int K_CUT   = 3;
  localparam int K_FULL  = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [W-1:0]  op_a = '0;
  logic [W-1:0]  op_b = '0;
  logic [1:0]    acc_lvl = '0;
  logic [PW-1:0] carry_cut = '0;
  logic [PW-1:0] product;

  int n_cmp = 0;
  int n_bad = 0;
  int maxerr [4] = '{0, 0, 0, 0};

  bit    pend = 1'b0;
  int    p_a, p_b, p_l, p_kind, p_exp;
  string p_req;
  int    last_base = 0;

  always #10 clk = ~clk;

  acc_mult #(.W(W)) uut (
    .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b),
    .acc_lvl(acc_lvl), .carry_cut(carry_cut), .product(product)
  );

  function automatic int err_bound(input int l);
    int k;
    int s;
    k = 2 * l + 2;
    s = 0;
    for (int c = 0; c < k; c++) s += (c + 1) << c;
    return s;
  endfunction

  task automatic check_eq(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_le(input string req, input int act, input int lim);
    n_cmp++;
    if (act > lim) begin
      n_bad++;
      $display("FAIL %s: got %0d expected <= %0d", req, act, lim);
    end
  endtask

  task automatic check_ge(input string req, input int act, input int lim);
    n_cmp++;
    if (act < lim) begin
      n_bad++;
      $display("FAIL %s: got %0d expected >= %0d", req, act, lim);
    end
  endtask

  task automatic evaluate(input int r);
    int ex;
    ex = p_a * p_b;
    case (p_kind)
      K_EXACT: check_eq(p_req, r, p_exp);
      K_APPX, K_BASE: begin
        check_le("R4", r, ex);
        check_le("R5", ex - r, err_bound(p_l));
        if (ex - r > maxerr[p_l]) maxerr[p_l] = ex - r;
        if (p_kind == K_BASE) last_base = r;
      end
      K_CUT: check_le("R8", r, last_base);
      K_FULL: begin
        check_le("R8", r, last_base);
        check_ge("R9", 2 * r, last_base);
      end
      default: ;
    endcase
  endtask

  // drive one operand set; result of the previous set is checked here
  task automatic step(input int a, input int b, input int l, input int m,
                      input int kind, input int expv, input string req);
    @(negedge clk);
    if (pend) evaluate(int'(product));
    op_a = W'(a); op_b = W'(b); acc_lvl = 2'(l); carry_cut = PW'(m);
    p_a = a & 8'hFF; p_b = b & 8'hFF; p_l = l; p_kind = kind;
    p_exp = expv; p_req = req; pend = 1'b1;
  endtask

  task automatic flush();
    @(negedge clk);
    if (pend) evaluate(int'(product));
    pend = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    op_a = 8'hFF; op_b = 8'hFF; acc_lvl = 2'd0;
    repeat (3) @(negedge clk);
    check_eq("R1", int'(product), 0);
    rst = 1'b0;

    // R2: output holds between edges, then shows the new product
    @(negedge clk);
    op_a = 8'd9; op_b = 8'd9;
    #1 check_eq("R2", int'(product), 65025);
    @(negedge clk);
    check_eq("R2", int'(product), 81);

    // R3: exhaustive exact level with random cut vectors
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++)
        step(a, b, 0, int'($urandom & 16'hFFFF), K_EXACT, a * b, "R3");

    // R7: compressor behaviour on 3*3
    for (int l = 1; l < 4; l++) step(3, 3, l, 0, K_EXACT, 7, "R7");

    // R4/R5: dense sweep per approximate level
    for (int l = 1; l < 4; l++)
      for (int a = 0; a < 256; a++)
        for (int k = 0; k < 64; k++)
          step(a, 4 * k + (a & 3), l, 0, K_APPX, 0, "R5");

    // R6: low span bits zero in either operand
    for (int l = 1; l < 4; l++)
      for (int x = 0; x < 256; x++) begin
        int hi;
        int o;
        hi = (x << (2 * l + 2)) & 8'hFF;
        o  = int'($urandom & 8'hFF);
        step(hi, o, l, 0, K_EXACT, hi * o, "R6");
        step(o, hi, l, 0, K_EXACT, hi * o, "R6");
      end

    // R10: single-bit or zero operand, any level and cut vector
    for (int l = 0; l < 4; l++)
      for (int s = 0; s < 9; s++)
        for (int o = 0; o < 256; o += 7) begin
          int p;
          p = (s < 8) ? (1 << s) : 0;
          step(p, o, l, int'($urandom & 16'hFFFF), K_EXACT, p * o, "R10");
          step(o, p, l, int'($urandom & 16'hFFFF), K_EXACT, p * o, "R10");
        end

    // R8/R9: same operands with no cuts, random cuts, all cuts
    for (int l = 1; l < 4; l++)
      for (int i = 0; i < 1000; i++) begin
        int a;
        int b;
        a = int'($urandom & 8'hFF);
        b = int'($urandom & 8'hFF);
        step(a, b, l, 0, K_BASE, 0, "R8");
        step(a, b, l, int'($urandom & 16'hFFFF), K_CUT, 0, "R8");
        step(a, b, l, 16'hFFFF, K_FULL, 0, "R9");
      end
    flush();

    // R5: approximation is active at every nonzero level
    for (int l = 1; l < 4; l++) begin
      check_ge("R5", maxerr[l], 1);
      check_le("R5", maxerr[l], err_bound(l));
    end

    // R1: reset in mid-run clears a nonzero product
    op_a = 8'd200; op_b = 8'd100; acc_lvl = 2'd0;
    @(negedge clk);
    check_eq("R3", int'(product), 20000);
    rst = 1'b1;
    @(negedge clk);
    check_eq("R1", int'(product), 0);

    summary();
    $finish;
  end
endmodule